// File: doc/BRIEF.md
# Steppable Two-Phase Clock Controller

This block derives two non-overlapping clock phases, A and B, from a fast reference clock. The target logic under debug is clocked by these phases. Each cycle of the derived clock is made of four quarter positions, and the block moves through them in a fixed order. It can run freely, stop, advance by a quarter, half or full cycle, or park in a chosen quarter. A rate select and a delay setting set how long each quarter lasts.

A debug controller drives the block with one-cycle command pulses on the reference clock. It reads back the current quarter, whether that quarter is valid, whether the clock is running, and whether a step or park movement is still in progress. The block rejects a step request it cannot carry out. The rejection is a one-cycle pulse, and the request changes nothing.

Top module: `phase_clk_ctrl`

## Requirements
- R1: After reset the block is stopped in quarter 0. Both phase outputs are low, `quarter_vld_o`=1, `running_o`=0, `busy_o`=0 and `step_rej_o`=0.
- R2: Quarter codes are 0 = phase B, 1 = gap B to A, 2 = phase A, 3 = gap A to B. `phi_b_o` is high only in quarter 0 and `phi_a_o` only in quarter 2. Both stay low until the first accepted run, step or park, and they are never high together.
- R3: Quarters advance only in the order 0,1,2,3,0. In quarters 0 and 2 a quarter lasts the divider for the selected rate: rate 1 = 4, rate 2 = 3, rate 3 = 6 reference cycles. Quarters 1 and 3 last that divider plus `delay_i` cycles. The first quarter of a movement starts counting at the edge that accepts the command.
- R4: When idle, a step of size code 1, 2 or 4 advances exactly that many quarters and then stops. Any other size code is rejected.
- R5: A step is accepted only while idle, with a legal size, and with no run, stop or park pulse in the same cycle. Otherwise `step_rej_o` pulses in the next cycle and the step changes no state. When several commands arrive together, stop wins over run, run over park, and park over step.
- R6: A park request while running stops the clock when it enters the target quarter. If the clock is in that quarter at that edge, it stops at once.
- R7: A park request while idle advances the clock to the target quarter and stops there. If the clock is already in that quarter, nothing happens.
- R8: A run pulse while running does not disturb the quarter timing. A stop pulse while idle changes nothing.
- R9: `quarter_vld_o` is high only while idle. `running_o` is high only while free running. `busy_o` is high only during a step or park movement. Exactly one of the three is high at any time.
- R10: A stop pulse while running or moving leaves the clock idle in the quarter it holds after that edge, and the clock stays there.
- R11: Rate 0 freezes the quarter position in every active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start free running (pulse) |
| stop_i | input | 1 | Stop at current quarter (pulse) |
| step_i | input | 1 | Step request (pulse) |
| step_size_i | input | 3 | Step size code: 1, 2 or 4 quarters |
| park_i | input | 1 | Park-in-quarter request (pulse) |
| park_q_i | input | 2 | Target quarter for park |
| rate_i | input | 2 | Rate select, 0 = frozen |
| delay_i | input | 3 | Extra cycles added to gap quarters |
| phi_a_o | output | 1 | Phase A clock |
| phi_b_o | output | 1 | Phase B clock |
| quarter_o | output | 2 | Current quarter position |
| quarter_vld_o | output | 1 | Quarter position valid (idle) |
| running_o | output | 1 | Free running |
| busy_o | output | 1 | Step or park movement in progress |
| step_rej_o | output | 1 | Step request rejected (one-cycle pulse) |

## Verification
The hardest case to reach is a command that lands while the clock is already moving. Examples are a step sent during a running or stepping phase, or a run pulse sent in the middle of a quarter that must not restart the quarter timer. The bench reaches these cases by watching `quarter_o` change at the ports and then timing its pulse a fixed number of cycles after that edge. Random rates, delays, step sizes and park targets then cover the many different quarter lengths. Each movement is timed against lengths the bench computes itself.

// File: rtl/phase_clk_pkg.sv
package phase_clk_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_RUN  = 2'd1,
    MD_STEP = 2'd2,
    MD_PARK = 2'd3
  } mode_e;

  localparam logic [1:0] Q_PHB  = 2'd0;
  localparam logic [1:0] Q_GAP1 = 2'd1;
  localparam logic [1:0] Q_PHA  = 2'd2;
  localparam logic [1:0] Q_GAP2 = 2'd3;
endpackage

// File: rtl/pcc_qtr_len.sv
module pcc_qtr_len #(
  parameter int DIV_R1 = 4,
  parameter int DIV_R2 = 3,
  parameter int DIV_R3 = 6,
  parameter int DLY_W  = 3,
  parameter int CNT_W  = 8
) (
  input  logic [1:0]       rate_i,
  input  logic [1:0]       quarter_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [CNT_W-1:0] len_o,
  output logic             frozen_o
);
  logic [CNT_W-1:0] base;

  always_comb begin
    unique case (rate_i)
      2'd1:    base = CNT_W'(DIV_R1);
      2'd2:    base = CNT_W'(DIV_R2);
      2'd3:    base = CNT_W'(DIV_R3);
      default: base = '0;
    endcase
    // gap quarters are the odd codes
    len_o = base + (quarter_i[0] ? CNT_W'(delay_i) : '0);
  end

  assign frozen_o = (rate_i == 2'd0);
endmodule

// File: rtl/pcc_qtr_timer.sv
module pcc_qtr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= keeps a shortened quarter from overrunning after a rate change
  assign tick_o = en_i && ((cnt_q + CNT_W'(1)) >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else if (en_i)               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import phase_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       stop_i,
  input  logic       step_i,
  input  logic [2:0] step_size_i,
  input  logic       park_i,
  input  logic [1:0] park_q_i,
  input  logic       tick_i,
  output mode_e      mode_o,
  output logic [1:0] quarter_o,
  output logic       start_o,
  output logic       rej_o
);
  mode_e      mode_q, mode_d;
  logic [1:0] qtr_q, qtr_d;
  logic [1:0] tgt_q, tgt_d;
  logic [2:0] rem_q, rem_d;
  logic       rej_q;
  logic       idle, size_ok;
  logic       stop_go, run_go, park_go, step_go;

  assign idle    = (mode_q == MD_IDLE);
  assign size_ok = (step_size_i == 3'd1) || (step_size_i == 3'd2) || (step_size_i == 3'd4);

  // priority: stop > run > park > step
  assign stop_go = stop_i && !idle;
  assign run_go  = !stop_i && run_i && (mode_q != MD_RUN);
  assign park_go = !stop_i && !run_i && park_i &&
                   ((mode_q == MD_RUN) || (idle && (park_q_i != qtr_q)));
  assign step_go = step_i && !stop_i && !run_i && !park_i && idle && size_ok;

  assign start_o = idle && (run_go || park_go || step_go);

  always_comb begin
    mode_d = mode_q;
    qtr_d  = qtr_q;
    tgt_d  = tgt_q;
    rem_d  = rem_q;
    if (tick_i) begin
      qtr_d = qtr_q + 2'd1;
      unique case (mode_q)
        MD_STEP: begin
          rem_d = rem_q - 3'd1;
          if (rem_q == 3'd1) mode_d = MD_IDLE;
        end
        MD_PARK: if (qtr_d == tgt_q) mode_d = MD_IDLE;
        default: ;
      endcase
    end
    if (stop_go) begin
      mode_d = MD_IDLE;
    end else if (run_go) begin
      mode_d = MD_RUN;
    end else if (park_go) begin
      tgt_d  = park_q_i;
      mode_d = (qtr_d == park_q_i) ? MD_IDLE : MD_PARK;
    end else if (step_go) begin
      rem_d  = step_size_i;
      mode_d = MD_STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_IDLE;
      qtr_q  <= Q_PHB;
      tgt_q  <= Q_PHB;
      rem_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      qtr_q  <= qtr_d;
      tgt_q  <= tgt_d;
      rem_q  <= rem_d;
      rej_q  <= step_i && !step_go;
    end
  end

  assign mode_o    = mode_q;
  assign quarter_o = qtr_q;
  assign rej_o     = rej_q;
endmodule

// File: rtl/pcc_phase_out.sv
module pcc_phase_out
  import phase_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] quarter_i,
  output logic       phi_a_o,
  output logic       phi_b_o
);
  logic drv_q;

  // outputs stay quiet until the first movement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      drv_q <= 1'b0;
    else if (start_i) drv_q <= 1'b1;
  end

  assign phi_a_o = drv_q && (quarter_i == Q_PHA);
  assign phi_b_o = drv_q && (quarter_i == Q_PHB);
endmodule

// File: rtl/phase_clk_ctrl.sv
module phase_clk_ctrl
  import phase_clk_pkg::*;
#(
  parameter int DIV_R1 = 4,
  parameter int DIV_R2 = 3,
  parameter int DIV_R3 = 6,
  parameter int DLY_W  = 3,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             step_i,
  input  logic [2:0]       step_size_i,
  input  logic             park_i,
  input  logic [1:0]       park_q_i,
  input  logic [1:0]       rate_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             phi_a_o,
  output logic             phi_b_o,
  output logic [1:0]       quarter_o,
  output logic             quarter_vld_o,
  output logic             running_o,
  output logic             busy_o,
  output logic             step_rej_o
);
  mode_e            mode;
  logic [CNT_W-1:0] len;
  logic             frozen, tick, start;

  pcc_qtr_len #(
    .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3),
    .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) u_len (
    .rate_i   (rate_i),
    .quarter_i(quarter_o),
    .delay_i  (delay_i),
    .len_o    (len),
    .frozen_o (frozen)
  );

  pcc_qtr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start),
    .en_i     ((mode != MD_IDLE) && !frozen),
    .len_i    (len),
    .tick_o   (tick)
  );

  pcc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .stop_i     (stop_i),
    .step_i     (step_i),
    .step_size_i(step_size_i),
    .park_i     (park_i),
    .park_q_i   (park_q_i),
    .tick_i     (tick),
    .mode_o     (mode),
    .quarter_o  (quarter_o),
    .start_o    (start),
    .rej_o      (step_rej_o)
  );

  pcc_phase_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .quarter_i(quarter_o),
    .phi_a_o  (phi_a_o),
    .phi_b_o  (phi_b_o)
  );

  assign running_o     = (mode == MD_RUN);
  assign busy_o        = (mode == MD_STEP) || (mode == MD_PARK);
  assign quarter_vld_o = (mode == MD_IDLE);
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       stop_i,
  input logic       step_i,
  input logic       phi_a_o,
  input logic       phi_b_o,
  input logic [1:0] quarter_o,
  input logic       quarter_vld_o,
  input logic       running_o,
  input logic       busy_o,
  input logic       step_rej_o
);
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi_a_o && phi_b_o)); // R2
  AST_PHASE_A_QTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi_a_o |-> (quarter_o == 2'd2)); // R2
  AST_PHASE_B_QTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi_b_o |-> (quarter_o == 2'd0)); // R2
  AST_QTR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(quarter_o) |-> (quarter_o == $past(quarter_o) + 2'd1)); // R3
  AST_STEP_REJ_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && running_o) |=> step_rej_o); // R5
  AST_STOP_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && quarter_vld_o) |=> (quarter_vld_o && $stable(quarter_o))); // R8
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && run_i && !stop_i) |=> running_o); // R8
  AST_STATUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({running_o, busy_o, quarter_vld_o}) == 1); // R9
endmodule

bind phase_clk_ctrl pcc_checker u_chk (.*);

// File: tb/tb_phase_clk_ctrl.sv
module tb_phase_clk_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 0, stop_i = 0, step_i = 0, park_i = 0;
  logic [2:0] step_size_i = 3'd1;
  logic [1:0] park_q_i = 2'd0;
  logic [1:0] rate_i = 2'd1;
  logic [2:0] delay_i = 3'd0;
  logic       phi_a_o, phi_b_o, quarter_vld_o, running_o, busy_o, step_rej_o;
  logic [1:0] quarter_o;

  int nchk = 0, nerr = 0, exp_q = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  phase_clk_ctrl #(.DIV_R1(4), .DIV_R2(3), .DIV_R3(6)) dut (.*);

  function automatic int qlen(int r, int q, int d);
    int b;
    case (r)
      1: b = 4;
      2: b = 3;
      3: b = 6;
      default: b = 0;
    endcase
    return b + ((q % 2 == 1) ? d : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_run();  run_i = 1;  @(negedge clk_i); run_i = 0;  endtask
  task automatic pulse_stop(); stop_i = 1; @(negedge clk_i); stop_i = 0; endtask

  // step from idle, timing and end state checked
  task automatic do_step(int sz);
    int exp_c = 0, c = 0, bad = 0;
    for (int k = 0; k < sz; k++) exp_c += qlen(rate_i, (exp_q + k) % 4, delay_i);
    step_size_i = 3'(sz); step_i = 1; @(negedge clk_i); step_i = 0;
    while (busy_o && c < 2000) begin
      if (quarter_vld_o || (phi_a_o != (quarter_o == 2)) || (phi_b_o != (quarter_o == 0))) bad++;
      @(negedge clk_i); c++;
    end
    exp_q = (exp_q + sz) % 4;
    chk("R4 step cycles", c, exp_c);
    chk("R4 step quarter", quarter_o, exp_q);
    chk("R2 phase decode during step", bad, 0);
  endtask

  task automatic do_park(int t);
    int exp_c = 0, c = 0, q = exp_q;
    while (q != t) begin exp_c += qlen(rate_i, q, delay_i); q = (q + 1) % 4; end
    park_q_i = 2'(t); park_i = 1; @(negedge clk_i); park_i = 0;
    while (busy_o && c < 2000) begin @(negedge clk_i); c++; end
    chk("R7 park cycles", c, exp_c);
    chk("R7 park quarter", quarter_o, t);
    chk("R7 park valid", quarter_vld_o, 1);
    exp_q = t;
  endtask

  // measure n running quarters; optional run pulse inside the 2nd one
  task automatic run_dwells(int n, bit inject);
    for (int i = 0; i < n; i++) begin
      int c = 0, qp = quarter_o;
      do begin
        if (inject && i == 1 && c == 1) run_i = 1;
        @(negedge clk_i); run_i = 0; c++;
      end while (quarter_o == 2'(qp) && c < 2000);
      chk(inject ? "R8 run-while-running dwell" : "R3 run dwell", c, qlen(rate_i, qp, delay_i));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 quarter", quarter_o, 0);
    chk("R1 valid", quarter_vld_o, 1);
    chk("R1 running", running_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 rej", step_rej_o, 0);
    chk("R2 phases low before start", {phi_a_o, phi_b_o}, 0);

    // R4 directed steps, R3 gap delay
    rate_i = 1; delay_i = 0;
    do_step(1);
    delay_i = 5; do_step(2);
    rate_i = 3; do_step(4);
    chk("R2 phase B in quarter 0", phi_b_o, (quarter_o == 0));
    // R4 illegal size
    step_size_i = 3'd3; step_i = 1; @(negedge clk_i); step_i = 0;
    chk("R4 illegal size rej", step_rej_o, 1);
    chk("R4 illegal size no move", {busy_o, quarter_o}, {1'b0, 2'(exp_q)});

    // R5 step during step
    step_size_i = 3'd4; step_i = 1; @(negedge clk_i); step_i = 0;
    step_size_i = 3'd1; step_i = 1; @(negedge clk_i); step_i = 0;
    chk("R5 step while busy rej", step_rej_o, 1);
    while (busy_o) @(negedge clk_i);
    chk("R5 first step unaffected", quarter_o, exp_q);

    // R7 park no-op and moves
    park_q_i = 2'(exp_q); park_i = 1; @(negedge clk_i); park_i = 0;
    chk("R7 park same quarter no-op", {busy_o, quarter_vld_o, quarter_o}, {2'b01, 2'(exp_q)});
    rate_i = 2; delay_i = 2;
    do_park((exp_q + 3) % 4);
    do_park((exp_q + 1) % 4);

    // R8 stop while idle
    pulse_stop();
    chk("R8 stop idle quarter", quarter_o, exp_q);
    chk("R8 stop idle valid", quarter_vld_o, 1);

    // R3 running timing, R9 status
    rate_i = 1; delay_i = 3;
    pulse_run();
    chk("R9 running flag", running_o, 1);
    chk("R9 valid low when running", quarter_vld_o, 0);
    run_dwells(5, 0);
    run_dwells(3, 1);

    // R5 step while running
    step_size_i = 3'd1; step_i = 1; @(negedge clk_i); step_i = 0;
    chk("R5 step while running rej", step_rej_o, 1);
    chk("R5 still running", {running_o, busy_o}, 2'b10);

    // R6 park while running
    park_q_i = 2'd2; park_i = 1; @(negedge clk_i); park_i = 0;
    begin
      int c = 0;
      while (!quarter_vld_o && c < 200) begin @(negedge clk_i); c++; end
    end
    chk("R6 parked quarter", quarter_o, 2);
    chk("R6 parked idle", {running_o, busy_o, quarter_vld_o}, 3'b001);
    chk("R2 phase A parked", {phi_a_o, phi_b_o}, 2'b10);
    exp_q = 2;

    // R10 stop while running
    pulse_run();
    repeat (13) @(negedge clk_i);
    pulse_stop();
    begin
      int qs = quarter_o;
      repeat (30) @(negedge clk_i);
      chk("R10 frozen after stop", quarter_o, qs);
      chk("R10 idle after stop", quarter_vld_o, 1);
      exp_q = qs;
    end

    // R11 rate 0 freezes
    rate_i = 0;
    pulse_run();
    repeat (40) @(negedge clk_i);
    chk("R11 rate 0 no advance", quarter_o, exp_q);
    chk("R11 rate 0 running", running_o, 1);
    pulse_stop();
    rate_i = 1;

    // R5 priority: run beats step
    step_size_i = 3'd1; step_i = 1; run_i = 1; @(negedge clk_i); step_i = 0; run_i = 0;
    chk("R5 concurrent run rej", step_rej_o, 1);
    chk("R5 run wins", running_o, 1);
    pulse_stop();
    exp_q = quarter_o;

    // random mix
    void'($urandom(32'h5eed_0011));
    for (int i = 0; i < 60; i++) begin
      int op = $urandom_range(0, 3);
      rate_i  = 2'($urandom_range(1, 3));
      delay_i = 3'($urandom_range(0, 7));
      @(negedge clk_i);
      if (op == 3) begin
        int t = $urandom_range(0, 3);
        if (t == exp_q) t = (t + 1) % 4;
        do_park(t);
      end else begin
        do_step(op == 0 ? 1 : (op == 1 ? 2 : 4));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule